// File: doc/BRIEF.md
# Emulated Printer Port Register File

This block is a byte-wide register file that sits on a host bus and pretends to be a legacy printer port with a printer already attached. It has no physical port pins. Software writes a byte to the data register, then toggles the strobe bit in the control register. The block then hands that byte to the rest of the chip as a one-cycle valid pulse carrying the byte. The printer's busy and acknowledge lines are not driven by any outside device. A small handshake state machine plays them back to software, and it advances on each status read. A level interrupt is raised when software pulses strobe low with interrupt enable set. It is cleared by the next status read.

The host side is a simple synchronous port. It has an address of which only the low three bits are decoded, write data, a write enable, a read enable and registered read data. A separate load strobe captures an external byte into the input data register. Software sees that register instead of the last written byte whenever the control direction bit is set.

The handshake state machine has three states. HS_HELD means busy and ack are both set. HS_ACKING means busy is clear and ack is set. HS_DRAINED means both are clear. It has these transitions:
- HS_HELD to HS_ACKING on a strobe-release control write.
- HS_ACKING to HS_DRAINED on a status read while the stored strobe bit is 0.
- HS_DRAINED to HS_HELD on a status read while the stored strobe bit is 0.
- Any state to HS_HELD on a control write with init low.
- Reset also enters HS_HELD.

Top module: `prn_port_regs`

## Requirements
- R1: Only addr[2:0] is decoded: 0 is data, 1 is status and 2 is control. A read of offsets 3 to 7 returns 0xFF. Read data appears on rd_data after the clock edge that samples rd_en, and it holds its value in cycles with no read. When wr_en and rd_en are both high, the write takes place and the read is ignored.
- R2: A control write stores the written value with bits 7 and 6 forced to 1. A control read returns the stored value.
- R3: A control write with bit 2 (init, active low) clear loads status with 0xD8. That value has busy (bit 7), ack (bit 6), online (bit 4) and error (bit 3) set, and the timeout bit (bit 0) clear.
- R4: A strobe-release control write clears status busy. A strobe-release write has bit 2 set, bit 3 (select) set and bit 0 (strobe) set. If the stored control bit 0 was 0 before that write, out_valid is high for exactly the one cycle after the write, and out_byte carries the data register. If the stored bit 0 was already 1, nothing is emitted.
- R5: A control write with bit 2 set, bit 3 set and bit 0 clear sets the pending interrupt, but only if the stored control bit 4 (interrupt enable) was 1 before the write. irq follows the pending flag from the cycle after the write. Data writes leave it unchanged.
- R6: A status read returns the status value from before the read, and it clears the pending interrupt, so irq is low after that edge.
- R7: A status read may advance the handshake, but only when busy is clear and the stored control bit 0 is 0. In that case, if ack was set it is cleared (0x58 becomes 0x18), and if ack was clear both ack and busy are set (0x18 becomes 0xD8). In all other cases the read leaves status unchanged.
- R8: A data read returns the input data register when control bit 5 (direction) is 1. Otherwise it returns the last written data byte. The input register loads in_byte on any cycle with in_load high.
- R9: After reset, a data read returns 0xFF with either direction setting, status reads 0xD9 and control reads 0xCC. Also after reset, irq and out_valid are 0 and rd_data is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register address; bits [2:0] decoded |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| in_load | input | 1 | Load in_byte into the input data register |
| in_byte | input | 8 | External input byte |
| irq | output | 1 | Level interrupt (pending flag) |
| out_valid | output | 1 | One-cycle pulse for an emitted byte |
| out_byte | output | 8 | Emitted byte, valid with out_valid |

## Verification
A wrong handshake state shows up as a wrong status value on the very next status read. Because every status read also advances the state, one bad transition makes the whole following sequence 0x58, 0x18, 0xD8 disagree from that read onward. A stale stored strobe bit shows up one cycle after a control write, either as a missing or doubled out_valid pulse, or as a handshake that freezes or advances when it should not. A wrong interrupt-enable sample or pending flag is visible on irq one cycle after the control write or the status read that should have changed it.

// File: rtl/prnp_pkg.sv
package prnp_pkg;

    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    localparam logic [2:0] OFS_DATA = 3'd0;
    localparam logic [2:0] OFS_STAT = 3'd1;
    localparam logic [2:0] OFS_CTRL = 3'd2;

    // control bit positions
    localparam int CB_STROBE = 0;
    localparam int CB_INIT   = 2;
    localparam int CB_SELECT = 3;
    localparam int CB_IRQEN  = 4;
    localparam int CB_DIR    = 5;

    localparam byte_t CTRL_FORCE  = 8'hC0;
    localparam byte_t CTRL_RESET  = 8'hCC;
    localparam byte_t DATA_RESET  = 8'hFF;
    localparam byte_t UNMAPPED_RD = 8'hFF;

    typedef enum logic [1:0] {
        HS_HELD    = 2'd0,
        HS_ACKING  = 2'd1,
        HS_DRAINED = 2'd2
    } hs_state_e;

    typedef struct packed {
        logic wr_data;
        logic wr_ctrl;
        logic rd_data;
        logic rd_stat;
        logic rd_ctrl;
        logic rd_none;
    } host_op_t;

endpackage

// File: rtl/prnp_host_decode.sv
module prnp_host_decode
    import prnp_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    output host_op_t          op
);

    logic [2:0] ofs;
    logic       rd_ok;

    assign ofs   = addr[2:0];
    assign rd_ok = rd_en && !wr_en;

    always_comb begin
        op = '0;
        if (wr_en) begin
            op.wr_data = (ofs == OFS_DATA);
            op.wr_ctrl = (ofs == OFS_CTRL);
        end
        if (rd_ok) begin
            unique case (ofs)
                OFS_DATA: op.rd_data = 1'b1;
                OFS_STAT: op.rd_stat = 1'b1;
                OFS_CTRL: op.rd_ctrl = 1'b1;
                default:  op.rd_none = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/prnp_ctrl_unit.sv
module prnp_ctrl_unit
    import prnp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  host_op_t op,
    input  byte_t    wdata,
    input  logic     in_load,
    input  byte_t    in_byte,
    output byte_t    ctrl_q,
    output byte_t    dout_q,
    output byte_t    din_q,
    output logic     init_evt,
    output logic     release_evt,
    output logic     pending_q,
    output logic     out_valid_q,
    output byte_t    out_byte_q
);

    byte_t ctrl_new;
    logic  armed;
    logic  emit_evt;
    logic  intr_evt;

    assign ctrl_new    = wdata | CTRL_FORCE;
    assign init_evt    = op.wr_ctrl && !ctrl_new[CB_INIT];
    assign armed       = op.wr_ctrl && ctrl_new[CB_INIT] && ctrl_new[CB_SELECT];
    assign release_evt = armed && ctrl_new[CB_STROBE];
    assign emit_evt    = release_evt && !ctrl_q[CB_STROBE];
    assign intr_evt    = armed && !ctrl_new[CB_STROBE] && ctrl_q[CB_IRQEN];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
            dout_q <= DATA_RESET;
            din_q  <= DATA_RESET;
        end else begin
            if (op.wr_ctrl) ctrl_q <= ctrl_new;
            if (op.wr_data) dout_q <= wdata;
            if (in_load)    din_q  <= in_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
        end else if (intr_evt) begin
            pending_q <= 1'b1;
        end else if (op.rd_stat) begin
            pending_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid_q <= 1'b0;
            out_byte_q  <= '0;
        end else begin
            out_valid_q <= emit_evt;
            if (emit_evt) out_byte_q <= dout_q;
        end
    end

endmodule

// File: rtl/prnp_handshake_fsm.sv
module prnp_handshake_fsm
    import prnp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  init_evt,
    input  logic  release_evt,
    input  logic  stat_rd,
    input  logic  strobe_held,
    output byte_t status
);

    hs_state_e state_q, state_d;
    logic      tmo_q;
    logic      busy, ack;
    logic      step;

    assign step = stat_rd && !strobe_held;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HS_HELD;
            tmo_q   <= 1'b1;
        end else begin
            state_q <= state_d;
            if (init_evt) tmo_q <= 1'b0;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (init_evt) begin
            state_d = HS_HELD;
        end else begin
            unique case (state_q)
                HS_HELD:    if (release_evt) state_d = HS_ACKING;
                HS_ACKING:  if (step)        state_d = HS_DRAINED;
                HS_DRAINED: if (step)        state_d = HS_HELD;
                default:                     state_d = HS_HELD;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy = 1'b1;
        ack  = 1'b1;
        unique case (state_q)
            HS_HELD:    begin busy = 1'b1; ack = 1'b1; end
            HS_ACKING:  begin busy = 1'b0; ack = 1'b1; end
            HS_DRAINED: begin busy = 1'b0; ack = 1'b0; end
            default:    begin busy = 1'b1; ack = 1'b1; end
        endcase
        status = {busy, ack, 1'b0, 1'b1, 1'b1, 2'b00, tmo_q};
    end

endmodule

// File: rtl/prn_port_regs.sv
module prn_port_regs
    import prnp_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rd_data,
    input  logic              in_load,
    input  logic [7:0]        in_byte,
    output logic              irq,
    output logic              out_valid,
    output logic [7:0]        out_byte
);

    host_op_t op;
    byte_t    ctrl_q, dout_q, din_q, status;
    logic     init_evt, release_evt, pending_q;
    byte_t    rd_q;

    prnp_host_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr  (addr),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .op    (op)
    );

    prnp_ctrl_unit u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .op          (op),
        .wdata       (wdata),
        .in_load     (in_load),
        .in_byte     (in_byte),
        .ctrl_q      (ctrl_q),
        .dout_q      (dout_q),
        .din_q       (din_q),
        .init_evt    (init_evt),
        .release_evt (release_evt),
        .pending_q   (pending_q),
        .out_valid_q (out_valid),
        .out_byte_q  (out_byte)
    );

    prnp_handshake_fsm u_hs (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_evt    (init_evt),
        .release_evt (release_evt),
        .stat_rd     (op.rd_stat),
        .strobe_held (ctrl_q[CB_STROBE]),
        .status      (status)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (op.rd_data) begin
            rd_q <= ctrl_q[CB_DIR] ? din_q : dout_q;
        end else if (op.rd_stat) begin
            rd_q <= status;
        end else if (op.rd_ctrl) begin
            rd_q <= ctrl_q;
        end else if (op.rd_none) begin
            rd_q <= UNMAPPED_RD;
        end
    end

    assign rd_data = rd_q;
    assign irq     = pending_q;

endmodule

// File: rtl/prnp_regs_chk.sv
module prnp_regs_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [7:0]        wdata,
    input logic [7:0]        rd_data,
    input logic              irq,
    input logic              out_valid
);

    a_r1_unmapped_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr[2:0] >= 3'd3) |=> (rd_data == 8'hFF));

    a_r1_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en || wr_en) |=> $stable(rd_data));

    a_r4_emit_single: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    a_r4_emit_cause: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(wr_en && addr[2:0] == 3'd2 && wdata[0] && wdata[2] && wdata[3]));

    a_r5_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(wr_en && addr[2:0] == 3'd2 && !wdata[0]));

    a_r6_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr[2:0] == 3'd1) |=> !irq);

endmodule

bind prn_port_regs prnp_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .wdata     (wdata),
    .rd_data   (rd_data),
    .irq       (irq),
    .out_valid (out_valid)
);

// File: tb/prn_port_regs_tb.sv
module prn_port_regs_tb;

    localparam int ADDR_W = 4;
    localparam int NVEC   = 21;

    // op: 0 write, 1 read+check, 2 load input
    localparam logic [25:0] VEC [NVEC] = '{
        {2'd1, 8'd0, 8'h00, 8'hFF},  // R9 data
        {2'd1, 8'd1, 8'h00, 8'hD9},  // R9 status
        {2'd1, 8'd2, 8'h00, 8'hCC},  // R9 control
        {2'd1, 8'd5, 8'h00, 8'hFF},  // R1 unmapped
        {2'd0, 8'd0, 8'hA5, 8'h00},
        {2'd1, 8'd0, 8'h00, 8'hA5},  // R8 written byte
        {2'd2, 8'd0, 8'h3C, 8'h00},
        {2'd1, 8'd0, 8'h00, 8'hA5},  // R8 dir 0
        {2'd0, 8'd2, 8'h2C, 8'h00},
        {2'd1, 8'd2, 8'h00, 8'hEC},  // R2 forced bits
        {2'd1, 8'd0, 8'h00, 8'h3C},  // R8 dir 1
        {2'd0, 8'd2, 8'h00, 8'h00},
        {2'd1, 8'd1, 8'h00, 8'hD8},  // R3 init
        {2'd0, 8'd2, 8'h0D, 8'h00},
        {2'd1, 8'd1, 8'h00, 8'h58},  // R7 strobe held
        {2'd0, 8'd2, 8'h0C, 8'h00},
        {2'd1, 8'd1, 8'h00, 8'h58},  // R7 ack clears next
        {2'd1, 8'd1, 8'h00, 8'h18},  // R7 busy+ack set next
        {2'd1, 8'd1, 8'h00, 8'hD8},  // R7 busy holds
        {2'd1, 8'd3, 8'h00, 8'hFF},  // R1 unmapped
        {2'd1, 8'd7, 8'h00, 8'hFF}   // R1 unmapped
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              wr_en = 1'b0, rd_en = 1'b0, in_load = 1'b0;
    logic [7:0]        wdata = '0, in_byte = '0;
    logic [7:0]        rd_data, out_byte;
    logic              irq, out_valid;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    prn_port_regs #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rd_data(rd_data), .in_load(in_load), .in_byte(in_byte),
        .irq(irq), .out_valid(out_valid), .out_byte(out_byte)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // one bus cycle: drive at negedge, results visible at next negedge
    task automatic cycle(input logic w, input logic r, input logic l,
                         input logic [ADDR_W-1:0] a, input logic [7:0] d);
        wr_en = w; rd_en = r; in_load = l; addr = a; wdata = d; in_byte = d;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; in_load = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        check("R9 irq", {7'd0, irq}, 8'h00);
        check("R9 out_valid", {7'd0, out_valid}, 8'h00);
        check("R9 rd_data", rd_data, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            logic [1:0] op;
            logic [7:0] a, d, e;
            {op, a, d, e} = VEC[i];
            cycle(op == 2'd0, op == 2'd1, op == 2'd2, a[ADDR_W-1:0], d);
            if (op == 2'd1) check($sformatf("R1/R7 vector %0d", i), rd_data, e);
        end

        // R4 emit on strobe rise (status D8, ctrl CC)
        cycle(1, 0, 0, 4'd0, 8'h5A);
        cycle(1, 0, 0, 4'd2, 8'h0D);
        check("R4 emit valid", {7'd0, out_valid}, 8'h01);
        check("R4 emit byte", out_byte, 8'h5A);
        @(negedge clk);
        check("R4 pulse width", {7'd0, out_valid}, 8'h00);
        cycle(1, 0, 0, 4'd2, 8'h0D);
        check("R4 no emit when strobe held", {7'd0, out_valid}, 8'h00);

        // R5 interrupt enable sampled from stored control
        cycle(1, 0, 0, 4'd2, 8'h1C);
        check("R5 irq needs stored enable", {7'd0, irq}, 8'h00);
        cycle(1, 0, 0, 4'd2, 8'h1C);
        check("R5 irq set", {7'd0, irq}, 8'h01);
        cycle(1, 0, 0, 4'd0, 8'h11);
        check("R5 irq kept over data write", {7'd0, irq}, 8'h01);

        // R6 status read returns old status and clears irq
        cycle(0, 1, 0, 4'd1, 8'h00);
        check("R6 status value", rd_data, 8'h58);
        check("R6 irq cleared", {7'd0, irq}, 8'h00);

        // R1 read ignored under simultaneous write
        cycle(1, 1, 0, 4'd0, 8'h22);
        check("R1 read ignored on write", rd_data, 8'h58);
        cycle(0, 1, 0, 4'd1, 8'h00);
        check("R7 ack cleared", rd_data, 8'h18);
        cycle(0, 1, 0, 4'b1010, 8'h00);
        check("R1 high address bits ignored", rd_data, 8'hDC);
        cycle(0, 1, 0, 4'b1000, 8'h00);
        check("R8 dir 0 shows written byte", rd_data, 8'h22);

        // R9 mid-run reset with irq pending and input loaded
        cycle(1, 0, 0, 4'd2, 8'h3C);
        cycle(1, 0, 0, 4'd2, 8'h3C);
        cycle(0, 0, 1, 4'd0, 8'h77);
        check("R5 irq before reset", {7'd0, irq}, 8'h01);
        do_reset();
        check("R9 irq after reset", {7'd0, irq}, 8'h00);
        cycle(0, 1, 0, 4'd2, 8'h00);
        check("R9 control after reset", rd_data, 8'hCC);
        cycle(0, 1, 0, 4'd1, 8'h00);
        check("R9 status after reset", rd_data, 8'hD9);
        cycle(1, 0, 0, 4'd2, 8'h2C);
        cycle(0, 1, 0, 4'd0, 8'h00);
        check("R9 input reg after reset", rd_data, 8'hFF);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule